// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register front end of an outer cache controller's maintenance engine. Several CPUs share it through one register port that carries the CPU index of every access. A CPU builds a command in a set of shared staging registers: a mode word, a start address, a size, an address mask and a way set. It then reads a result register. That read either puts the command into a single shared FIFO or reports why it could not. A hardware ownership right keeps each build-and-post sequence atomic. The first CPU to write the mode word holds the right until it reads its result, and attempts by any other CPU in that window fail.

Queued commands run strictly one after another. The execution model is a countdown whose length follows the command's size in cache lines, scaled by a latency input that software can change. Each completion appears for one cycle on a set of result ports. If the command asked for notification, the completion also sets an end flag in the issuing CPU's own status register. Result and status registers exist once per CPU, so a CPU sees only its own commands. A primitive entry register gives a buffer drain request, a prefetch-buffer flush request and an idle poll.

Top module: `cmq_top`

## Requirements
- R1: After reset, the status, result and primitive-entry reads return 0 for every CPU, and done_o is low.
- R2: A mode write (offset 0x248) takes the ownership right when it is free or already held by the writer. While another CPU holds the right, a CPU's writes to offsets 0x248, 0x24C, 0x250, 0x254 and 0x258 are ignored. That CPU's next read of the result register (0x25C) then returns 1.
- R3: A result read by the owner releases the right. It returns 0 and queues the command, or it returns 2 and drops the command when DEPTH commands are already waiting.
- R4: The mode word is decoded as follows. Bits [2:0] are the operation: 0 invalidate, 1 clean, 2 flush, 3 prefetch to cache, 4 prefetch to buffer, 5 touch, 6 touch to zero, 7 touch with dirty. Bits [18:17] are the scope: 0 range, 1 whole, 2 by way. Bits [22:21] are the target: 0 LRU data, 1 LRU instruction, 2 by way. Bit 15 requests notification. All of these, together with the issuing CPU, the address, the mask and the ways, appear on the done_* ports.
- R5: A range command into an idle engine raises done_o in the cycle N clock edges after the edge that accepts its result read. N = ceil(size/LINE_BYTES) × max(lat_i,1), with a minimum of 1, and lat_i is sampled when the command starts.
- R6: A command of any scope other than 0 runs for ALL_CYC cycles, whatever its size.
- R7: Commands complete in queue order, and each queued command starts in the cycle right after the previous one completes.
- R8: Status bit 2 (offset 0x260) is set when a command of that CPU with bit 15 completes. Writing a 1 to bit 2 clears it, but a set in the same cycle wins. A command without bit 15 leaves the bit at 0.
- R9: Status bit 0 shows that the CPU has a command queued or running. Bit 1 shows that one of its commands is running. Other CPUs' commands do not affect either bit.
- R10: Writing 0x8 to offset 0x244 pulses drain_o and writing 0x9 pulses pf_flush_o, each in the cycle after the write. Other values pulse neither. A read of 0x244 returns 1 while any command is queued or running, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access in this cycle |
| we_i | input | 1 | 1 write, 0 read |
| cpu_i | input | CPU_W | Index of the accessing CPU |
| addr_i | input | 12 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| lat_i | input | LAT_W | Cycles per cache line for range commands |
| drain_o | output | 1 | Buffer drain request pulse |
| pf_flush_o | output | 1 | Prefetch buffer flush pulse |
| done_o | output | 1 | A command completes in this cycle |
| done_cpu_o | output | CPU_W | Issuing CPU of the completing command |
| done_op_o | output | 3 | Operation code |
| done_scope_o | output | 2 | Scope code |
| done_target_o | output | 2 | Target code |
| done_addr_o | output | 32 | Start address |
| done_mask_o | output | 32 | Address mask |
| done_ways_o | output | 8 | Way set |

## Verification
Two events can land in the same cycle: a CPU writing the clear bit of its end flag, and the engine completing a notifying command for that same CPU. The bench waits for done_o, then issues the clear write in that very cycle. It then reads the status register and expects 4, because the new completion must not be lost. The register-then-release sequence is also run in interleaved form between two CPUs, and in the cycle where the FIFO is at capacity.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
  localparam int unsigned CPU_IW = 2;
  localparam int unsigned AW     = 32;
  localparam int unsigned WW     = 8;

  localparam logic [11:0] OFS_PRIM = 12'h244;
  localparam logic [11:0] OFS_MODE = 12'h248;
  localparam logic [11:0] OFS_ADDR = 12'h24C;
  localparam logic [11:0] OFS_SIZE = 12'h250;
  localparam logic [11:0] OFS_MASK = 12'h254;
  localparam logic [11:0] OFS_WAYS = 12'h258;
  localparam logic [11:0] OFS_RES  = 12'h25C;
  localparam logic [11:0] OFS_STAT = 12'h260;

  localparam logic [31:0] PRIM_DRAIN = 32'h8;
  localparam logic [31:0] PRIM_PFFL  = 32'h9;

  typedef enum logic [2:0] {
    OP_INV, OP_CLEAN, OP_FLUSH, OP_PF_CACHE,
    OP_PF_BUF, OP_TOUCH, OP_TOUCH_ZERO, OP_TOUCH_DIRTY
  } op_e;

  typedef enum logic [1:0] {
    SC_RANGE = 2'd0, SC_ALL = 2'd1, SC_WAY = 2'd2, SC_RSVD = 2'd3
  } scope_e;

  typedef struct packed {
    op_e               op;
    scope_e            scope;
    logic [1:0]        target;
    logic              notify;
    logic [CPU_IW-1:0] cpu;
    logic [AW-1:0]     addr;
    logic [AW-1:0]     size;
    logic [AW-1:0]     mask;
    logic [WW-1:0]     ways;
  } cmd_t;
endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter type         T     = logic,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  T              data_i,
  input  logic          pop_i,
  output T              head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  T              mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/cmq_exec.sv
module cmq_exec
  import cmq_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned ALL_CYC    = 16,
  parameter int unsigned LAT_W      = 4,
  localparam int unsigned LINE_SH   = $clog2(LINE_BYTES),
  localparam int unsigned CNT_W     = AW + 1 + LAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             empty_i,
  input  cmd_t             head_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             done_o,
  output cmd_t             cur_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  cmd_t             cur_q;

  function automatic logic [CNT_W-1:0] run_len(cmd_t c, logic [LAT_W-1:0] lat);
    logic [AW:0]      lines;
    logic [LAT_W-1:0] per;
    logic [CNT_W-1:0] n;
    lines = ({1'b0, c.size} + (AW+1)'(LINE_BYTES - 1)) >> LINE_SH;
    per   = (lat == '0) ? LAT_W'(1) : lat;
    n     = CNT_W'(lines) * CNT_W'(per);
    if (c.scope != SC_RANGE) n = CNT_W'(ALL_CYC);
    else if (n == '0)        n = CNT_W'(1);
    return n;
  endfunction

  assign done_o = busy_q && (cnt_q == CNT_W'(1));
  assign pop_o  = !empty_i && (!busy_q || done_o);
  assign busy_o = busy_q;
  assign cur_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cur_q  <= '0;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      cnt_q  <= run_len(head_i, lat_i);
      cur_q  <= head_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cmq_regs.sv
module cmq_regs
  import cmq_pkg::*;
#(
  parameter int unsigned N_CPU = 2,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CPU_W = $clog2(N_CPU),
  localparam int unsigned PDW   = $clog2(DEPTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [CPU_W-1:0] cpu_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             full_i,
  input  logic             idle_i,
  output logic             push_o,
  output cmd_t             push_cmd_o,
  input  logic             done_i,
  input  logic             busy_i,
  input  cmd_t             cur_i,
  output logic             drain_o,
  output logic             pf_flush_o,
  output logic             lock_held_o,
  output logic [CPU_W-1:0] lock_owner_o,
  output logic [N_CPU-1:0] end_flag_o
);
  logic             own_v_q;
  logic [CPU_W-1:0] own_q;
  op_e              op_q;
  scope_e           scope_q;
  logic [1:0]       target_q;
  logic             notify_q;
  logic [AW-1:0]    addr_q, size_q, mask_q;
  logic [WW-1:0]    ways_q;
  logic             drain_q, pfl_q;

  logic             wr, rd, is_owner, mode_take, release_rd, stage_wr;
  logic [N_CPU-1:0] err_v;
  logic [2:0]       stat_v [N_CPU];

  assign wr         = req_i && we_i;
  assign rd         = req_i && !we_i;
  assign is_owner   = own_v_q && (own_q == cpu_i);
  assign mode_take  = wr && (addr_i == OFS_MODE) && (!own_v_q || own_q == cpu_i);
  assign release_rd = rd && (addr_i == OFS_RES) && is_owner;
  assign stage_wr   = wr && (addr_i == OFS_MODE || addr_i == OFS_ADDR ||
                             addr_i == OFS_SIZE || addr_i == OFS_MASK ||
                             addr_i == OFS_WAYS);
  assign push_o     = release_rd && !full_i;

  always_comb begin
    push_cmd_o        = '0;
    push_cmd_o.op     = op_q;
    push_cmd_o.scope  = scope_q;
    push_cmd_o.target = target_q;
    push_cmd_o.notify = notify_q;
    push_cmd_o.cpu    = CPU_IW'(own_q);
    push_cmd_o.addr   = addr_q;
    push_cmd_o.size   = size_q;
    push_cmd_o.mask   = mask_q;
    push_cmd_o.ways   = ways_q;
  end

  // shared right and staging registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_v_q  <= 1'b0;
      own_q    <= '0;
      op_q     <= OP_INV;
      scope_q  <= SC_RANGE;
      target_q <= '0;
      notify_q <= 1'b0;
      addr_q   <= '0;
      size_q   <= '0;
      mask_q   <= '0;
      ways_q   <= '0;
      drain_q  <= 1'b0;
      pfl_q    <= 1'b0;
    end else begin
      drain_q <= wr && (addr_i == OFS_PRIM) && (wdata_i == PRIM_DRAIN);
      pfl_q   <= wr && (addr_i == OFS_PRIM) && (wdata_i == PRIM_PFFL);
      if (mode_take) begin
        own_v_q  <= 1'b1;
        own_q    <= cpu_i;
        op_q     <= op_e'(wdata_i[2:0]);
        scope_q  <= scope_e'(wdata_i[18:17]);
        target_q <= wdata_i[22:21];
        notify_q <= wdata_i[15];
      end else if (release_rd) begin
        own_v_q  <= 1'b0;
      end
      if (wr && is_owner) begin
        case (addr_i)
          OFS_ADDR: addr_q <= wdata_i;
          OFS_SIZE: size_q <= wdata_i;
          OFS_MASK: mask_q <= wdata_i;
          OFS_WAYS: ways_q <= wdata_i[WW-1:0];
          default: ;
        endcase
      end
    end
  end

  // per-CPU result and status
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic           sel, err_q, ef_q, set_ef, clr_ef, inc, dec, mine_run;
    logic [PDW-1:0] pend_q;

    assign sel      = req_i && (cpu_i == CPU_W'(c));
    assign mine_run = cur_i.cpu == CPU_IW'(c);
    assign set_ef   = done_i && cur_i.notify && mine_run;
    assign clr_ef   = sel && we_i && (addr_i == OFS_STAT) && wdata_i[2];
    assign inc      = push_o && (own_q == CPU_W'(c));
    assign dec      = done_i && mine_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        err_q  <= 1'b0;
        ef_q   <= 1'b0;
        pend_q <= '0;
      end else begin
        if (sel && mode_take)
          err_q <= 1'b0;
        else if (sel && stage_wr && !is_owner)
          err_q <= 1'b1;
        else if (sel && rd && (addr_i == OFS_RES) && !is_owner)
          err_q <= 1'b0;
        ef_q <= set_ef || (ef_q && !clr_ef);
        case ({inc, dec})
          2'b10:   pend_q <= pend_q + PDW'(1);
          2'b01:   pend_q <= pend_q - PDW'(1);
          default: pend_q <= pend_q;
        endcase
      end
    end

    assign err_v[c]      = err_q;
    assign end_flag_o[c] = ef_q;
    assign stat_v[c]     = {ef_q, busy_i && mine_run, pend_q != '0};
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        OFS_RES:  rdata_o = is_owner ? {30'b0, full_i, 1'b0} : {31'b0, err_v[cpu_i]};
        OFS_STAT: rdata_o = {29'b0, stat_v[cpu_i]};
        OFS_PRIM: rdata_o = {31'b0, !idle_i};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign drain_o      = drain_q;
  assign pf_flush_o   = pfl_q;
  assign lock_held_o  = own_v_q;
  assign lock_owner_o = own_q;
endmodule

// File: rtl/cmq_top.sv
module cmq_top
  import cmq_pkg::*;
#(
  parameter int unsigned N_CPU      = 2,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned ALL_CYC    = 16,
  parameter int unsigned LAT_W      = 4,
  localparam int unsigned CPU_W     = $clog2(N_CPU),
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [CPU_W-1:0] cpu_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [LAT_W-1:0] lat_i,
  output logic             drain_o,
  output logic             pf_flush_o,
  output logic             done_o,
  output logic [CPU_W-1:0] done_cpu_o,
  output logic [2:0]       done_op_o,
  output logic [1:0]       done_scope_o,
  output logic [1:0]       done_target_o,
  output logic [31:0]      done_addr_o,
  output logic [31:0]      done_mask_o,
  output logic [7:0]       done_ways_o
);
  cmd_t             push_cmd, head, cur_cmd;
  logic             push, pop, fifo_full, fifo_empty, exec_busy, lock_held;
  logic [CW-1:0]    fifo_cnt;
  logic [CPU_W-1:0] lock_owner;
  logic [N_CPU-1:0] end_flag;

  cmq_regs #(.N_CPU(N_CPU), .DEPTH(DEPTH)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .cpu_i, .addr_i, .wdata_i, .rdata_o,
    .full_i      (fifo_full),
    .idle_i      (fifo_empty && !exec_busy),
    .push_o      (push),
    .push_cmd_o  (push_cmd),
    .done_i      (done_o),
    .busy_i      (exec_busy),
    .cur_i       (cur_cmd),
    .drain_o, .pf_flush_o,
    .lock_held_o (lock_held),
    .lock_owner_o(lock_owner),
    .end_flag_o  (end_flag)
  );

  cmq_fifo #(.DEPTH(DEPTH), .T(cmd_t)) i_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (push_cmd),
    .pop_i  (pop),
    .head_o (head),
    .full_o (fifo_full),
    .empty_o(fifo_empty),
    .cnt_o  (fifo_cnt)
  );

  cmq_exec #(.LINE_BYTES(LINE_BYTES), .ALL_CYC(ALL_CYC), .LAT_W(LAT_W)) i_exec (
    .clk_i, .rst_ni, .lat_i,
    .empty_i(fifo_empty),
    .head_i (head),
    .pop_o  (pop),
    .busy_o (exec_busy),
    .done_o (done_o),
    .cur_o  (cur_cmd)
  );

  assign done_cpu_o    = cur_cmd.cpu[CPU_W-1:0];
  assign done_op_o     = cur_cmd.op;
  assign done_scope_o  = cur_cmd.scope;
  assign done_target_o = cur_cmd.target;
  assign done_addr_o   = cur_cmd.addr;
  assign done_mask_o   = cur_cmd.mask;
  assign done_ways_o   = cur_cmd.ways;
endmodule

// File: rtl/cmq_chk.sv
module cmq_chk #(
  parameter int unsigned N_CPU = 2,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CPU_W = $clog2(N_CPU),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [CPU_W-1:0] cpu_i,
  input logic [11:0]      addr_i,
  input logic [31:0]      wdata_i,
  input logic             lock_held,
  input logic [CPU_W-1:0] lock_owner,
  input logic [CW-1:0]    fifo_cnt,
  input logic             fifo_empty,
  input logic             exec_busy,
  input logic             done_o,
  input logic             done_notify,
  input logic [CPU_W-1:0] done_cpu,
  input logic [N_CPU-1:0] end_flag,
  input logic             drain_o,
  input logic             pf_flush_o
);
  // R2
  lock_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_held && req_i && we_i && addr_i == 12'h248 && cpu_i != lock_owner
    |=> lock_held && lock_owner == $past(lock_owner));

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  // R7
  start_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_empty && (!exec_busy || done_o) |=> exec_busy);

  // R8
  end_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_notify |=> end_flag[$past(done_cpu)]);

  // R10
  drain_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_o |-> $past(req_i && we_i && addr_i == 12'h244 && wdata_i == 32'h8));

  // R10
  pfl_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_flush_o |-> $past(req_i && we_i && addr_i == 12'h244 && wdata_i == 32'h9));
endmodule

bind cmq_top cmq_chk #(.N_CPU(N_CPU), .DEPTH(DEPTH)) i_cmq_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .cpu_i, .addr_i, .wdata_i,
  .lock_held, .lock_owner, .fifo_cnt, .fifo_empty, .exec_busy, .done_o,
  .done_notify(cur_cmd.notify),
  .done_cpu   (done_cpu_o),
  .end_flag, .drain_o, .pf_flush_o
);

// File: tb/test_cmq_top.sv
module test_cmq_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 64;
  localparam int ALLC = 16;
  localparam int DEP  = 4;

  localparam logic [11:0] A_PRIM = 12'h244, A_MODE = 12'h248, A_ADDR = 12'h24C,
                          A_SIZE = 12'h250, A_MASK = 12'h254, A_WAYS = 12'h258,
                          A_RES  = 12'h25C, A_STAT = 12'h260;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [0:0]  cpu_i = '0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [3:0]  lat_i = 4'd1;
  logic        drain_o, pf_flush_o, done_o;
  logic [0:0]  done_cpu_o;
  logic [2:0]  done_op_o;
  logic [1:0]  done_scope_o, done_target_o;
  logic [31:0] done_addr_o, done_mask_o;
  logic [7:0]  done_ways_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmq_top i_cmq_top (
    .clk_i, .rst_ni, .req_i, .we_i, .cpu_i, .addr_i, .wdata_i, .rdata_o, .lat_i,
    .drain_o, .pf_flush_o, .done_o, .done_cpu_o, .done_op_o, .done_scope_o,
    .done_target_o, .done_addr_o, .done_mask_o, .done_ways_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int cpu, logic [11:0] a, logic [31:0] d);
    req_i = 1; we_i = 1; cpu_i = cpu[0:0]; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(int cpu, logic [11:0] a, output logic [31:0] d);
    req_i = 1; we_i = 0; cpu_i = cpu[0:0]; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 0;
  endtask

  function automatic logic [31:0] mode(int op, int scope, int tgt, bit ntf);
    return 32'(op) | (32'(scope) << 17) | (32'(tgt) << 21) | (32'(ntf) << 15);
  endfunction

  task automatic post(int cpu, logic [31:0] m, logic [31:0] a, logic [31:0] s,
                      logic [31:0] mk, logic [31:0] w, output logic [31:0] res);
    bus_wr(cpu, A_MODE, m);
    bus_wr(cpu, A_ADDR, a);
    bus_wr(cpu, A_SIZE, s);
    bus_wr(cpu, A_MASK, mk);
    bus_wr(cpu, A_WAYS, w);
    bus_rd(cpu, A_RES, res);
  endtask

  task automatic wait_done(output int j);
    j = 0;
    while (!done_o && j < 5000) begin @(negedge clk_i); j++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int j, e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 done_o", 32'(done_o), 0);
    for (int c = 0; c < 2; c++) begin
      bus_rd(c, A_STAT, r); chk("R1 status", r, 0);
      bus_rd(c, A_RES, r);  chk("R1 result", r, 0);
    end
    bus_rd(0, A_PRIM, r); chk("R1/R10 prim idle", r, 0);

    // R5 latency sweep over size and lat_i
    for (int l = 0; l < 4; l++) begin
      for (int k = 0; k < 6; k++) begin
        int sz;
        sz = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 63 : (k == 3) ? 64 : (k == 4) ? 65 : 200;
        lat_i = l[3:0];
        post(0, mode(2, 0, 0, 0), 32'h100 * k, sz, 0, 0, r);
        chk("R3 accept", r, 0);
        wait_done(j);
        e = ((sz + LINE - 1) / LINE) * ((l == 0) ? 1 : l);
        if (e == 0) e = 1;
        chk("R5 latency", j, e);
        @(negedge clk_i);
      end
    end
    bus_rd(0, A_STAT, r); chk("R8 no notify leaves flag clear", r, 0);

    // R4/R6 field sweep, whole/way/reserved scope
    lat_i = 4'd2;
    for (int sc = 1; sc < 4; sc++) begin
      for (int op = 0; op < 8; op++) begin
        for (int tg = 0; tg < 3; tg++) begin
          post(1, mode(op, sc, tg, 0), 32'h40 * op, 32'd5000, 0, 0, r);
          wait_done(j);
          chk("R6 whole latency", j, ALLC);
          chk("R4 op", 32'(done_op_o), op);
          chk("R4 scope", 32'(done_scope_o), sc);
          chk("R4 target", 32'(done_target_o), tg);
          chk("R4 cpu", 32'(done_cpu_o), 1);
          @(negedge clk_i);
        end
      end
    end

    // R8/R9 status bits
    lat_i = 4'd3;
    post(1, mode(1, 0, 0, 1), 32'h2000, 32'd640, 0, 0, r);
    bus_rd(1, A_STAT, r); chk("R9 queued", r, 1);
    bus_rd(1, A_STAT, r); chk("R9 running", r, 3);
    bus_rd(0, A_STAT, r); chk("R9 other cpu", r, 0);
    bus_rd(0, A_PRIM, r); chk("R10 prim busy", r, 1);
    wait_done(j);
    @(negedge clk_i);
    bus_rd(1, A_STAT, r); chk("R8 end flag", r, 4);
    bus_rd(0, A_STAT, r); chk("R8 other cpu", r, 0);
    bus_wr(1, A_STAT, 32'h4);
    bus_rd(1, A_STAT, r); chk("R8 clear", r, 0);

    // R8 set and clear in the same cycle
    lat_i = 4'd1;
    post(1, mode(0, 0, 0, 1), 32'h3000, 32'd128, 0, 0, r);
    wait_done(j);
    bus_wr(1, A_STAT, 32'h4);
    bus_rd(1, A_STAT, r); chk("R8 set wins over clear", r, 4);
    bus_wr(1, A_STAT, 32'h4);
    bus_rd(1, A_STAT, r); chk("R8 clear after", r, 0);

    // R2 ownership
    bus_wr(0, A_MODE, mode(1, 0, 0, 0));
    bus_wr(1, A_MODE, mode(2, 1, 0, 0));
    bus_wr(1, A_ADDR, 32'hDEAD0000);
    bus_wr(0, A_ADDR, 32'h1000);
    bus_wr(0, A_SIZE, 32'd64);
    bus_wr(1, A_SIZE, 32'd9999);
    bus_wr(0, A_MASK, 32'h3F);
    bus_wr(0, A_WAYS, 32'h5);
    bus_rd(1, A_RES, r); chk("R2 blocked result", r, 1);
    bus_rd(0, A_RES, r); chk("R2 owner result", r, 0);
    wait_done(j);
    chk("R2 latency unaffected", j, 1);
    chk("R2 addr", done_addr_o, 32'h1000);
    chk("R2 op", 32'(done_op_o), 1);
    chk("R2 scope", 32'(done_scope_o), 0);
    chk("R2 cpu", 32'(done_cpu_o), 0);
    chk("R4 mask", done_mask_o, 32'h3F);
    chk("R4 ways", 32'(done_ways_o), 5);
    @(negedge clk_i);
    post(1, mode(0, 0, 0, 0), 32'h5000, 32'd64, 0, 0, r);
    chk("R2 retry accepted", r, 0);
    wait_done(j);
    chk("R2 retry cpu", 32'(done_cpu_o), 1);
    chk("R2 retry addr", done_addr_o, 32'h5000);
    @(negedge clk_i);

    // R3/R7 full queue and ordering
    lat_i = 4'd15;
    post(0, mode(2, 0, 0, 0), 32'hA000, 32'd1024, 0, 0, r);
    chk("R3 head", r, 0);
    for (int k = 1; k <= DEP; k++) begin
      post(0, mode(2, 0, 0, 0), 32'hA000 + 32'(k), 32'd64, 0, 0, r);
      chk("R3 fill", r, 0);
    end
    post(0, mode(2, 0, 0, 0), 32'hAFFF, 32'd64, 0, 0, r);
    chk("R3 full", r, 2);
    bus_wr(1, A_MODE, mode(0, 0, 0, 0));
    bus_rd(1, A_RES, r); chk("R3 released on full", r, 2);
    lat_i = 4'd1;
    wait_done(j);
    chk("R7 first", done_addr_o, 32'hA000);
    for (int k = 1; k <= DEP; k++) begin
      @(negedge clk_i);
      chk("R7 back-to-back", 32'(done_o), 1);
      chk("R7 order", done_addr_o, 32'hA000 + 32'(k));
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      chk("R3 dropped command", 32'(done_o), 0);
    end

    // R10 primitive entry
    bus_wr(0, A_PRIM, 32'h8);
    chk("R10 drain", 32'(drain_o), 1);
    chk("R10 no pf flush", 32'(pf_flush_o), 0);
    bus_wr(1, A_PRIM, 32'h9);
    chk("R10 pf flush", 32'(pf_flush_o), 1);
    chk("R10 no drain", 32'(drain_o), 0);
    bus_wr(0, A_PRIM, 32'h3);
    chk("R10 other code drain", 32'(drain_o), 0);
    chk("R10 other code pf", 32'(pf_flush_o), 0);
    bus_rd(0, A_PRIM, r); chk("R10 idle", r, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule